// File: doc/BRIEF.md
# Chained Receive Descriptor Walker

This block moves received frames into memory under the control of a chain of descriptors. Software lays out four-word descriptors in a shared word memory, each naming a byte buffer, its size and the address of the next descriptor, and marks each descriptor it hands over with an ownership bit. Once started, the engine fetches the current descriptor. If the engine owns it, the engine writes one incoming frame into the buffer and then writes a completion word back into the descriptor. That write returns the descriptor to software. The engine then moves on to the next descriptor.

When the engine meets a descriptor that software still holds, it raises a buffer-unavailable flag and waits. A poll strobe makes it fetch the same descriptor again. Software reaches the memory through a simple word port. Two sticky status flags (frame done and buffer unavailable) are cleared by writing a one to them.

Top module: `rxdesc_walker`

## Requirements
- R1: After reset `stat_o` is 0 and `rx_ready_o` is 0. The engine neither accepts bytes nor writes memory until `start_i` is seen high, at which point it takes `base_i` as the first descriptor address.
- R2: Descriptor layout, in memory words from the descriptor address: word 0 bit 31 is ownership (1 means the engine may fill it); word 1 bits 13:0 are the buffer size in bytes and bit 14 is the chain flag; word 2 is the buffer word address; word 3 is the next-descriptor word address. The engine reads all four words in order and then, if it owns the descriptor, raises `rx_ready_o` to accept a frame.
- R3: Frame byte k goes to buffer word (buffer address + k/4), byte lane k mod 4 (lane 0 in bits 7:0). Lanes past the final byte of the last word are written as zero.
- R4: After the last byte, word 0 of the descriptor is overwritten with bit 31 = 0, the stored length in bits 29:16, bit 9 and bit 8 (first and last segment) set, and every other bit zero except bit 15.
- R5: Bit 15 of the written-back word (error summary) is set when `rx_err_i` is high alongside the last byte.
- R6: Bytes past the buffer size are still accepted but not stored. The length then equals the buffer size and bit 15 is set. A frame that exactly fills the buffer leaves bit 15 clear. No memory word beyond the buffer is changed.
- R7: With the chain flag set, the next descriptor is the one at word 3. With it clear, the next descriptor starts four words after the current one, and word 3 is ignored.
- R8: A descriptor with bit 31 clear sets `stat_o[1]`, keeps `rx_ready_o` low and leaves the descriptor untouched.
- R9: `poll_i` while stalled makes the engine fetch the same descriptor again. The engine stalls again if the descriptor is still software-owned, and receives into it if it has been handed over.
- R10: `stat_o[0]` is set after each written-back frame. A one on `stat_clr_i[n]` clears `stat_o[n]`. A set and a clear in the same cycle leave the flag set.
- R11: `sw_we_i` writes `sw_wdata_i` to word `sw_addr_i`. `sw_rdata_o` shows the word at `sw_addr_i` one clock later.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Run enable, sampled while idle |
| base_i | input | AW | Word address of the first descriptor |
| poll_i | input | 1 | Resume strobe while stalled |
| rx_valid_i | input | 1 | Frame byte valid |
| rx_data_i | input | 8 | Frame byte |
| rx_last_i | input | 1 | Marks the final byte of a frame |
| rx_err_i | input | 1 | Frame error, qualified by the last byte |
| rx_ready_o | output | 1 | Engine accepts a byte this cycle |
| sw_we_i | input | 1 | Software memory write enable |
| sw_addr_i | input | AW | Software memory word address |
| sw_wdata_i | input | 32 | Software write data |
| sw_rdata_o | output | 32 | Software read data, one cycle latency |
| stat_clr_i | input | 2 | Write-one-to-clear for the status flags |
| stat_o | output | 2 | Bit 1 buffer unavailable, bit 0 frame done |

## Verification
Two events can land on the frame-done flag in the same cycle: the write-back of a frame sets it, and a software clear can arrive at the same time. The bench drives `stat_clr_i[0]` in the cycle right after the final byte is accepted, which is the write-back cycle, and expects the flag to read as set afterwards. A second pair, the buffer-unavailable flag being set again and being cleared by software, is driven by clearing the flag and polling a descriptor that is still software-owned. The flag must come back.

// File: rtl/rxw_pkg.sv
package rxw_pkg;
  localparam int WORD_W    = 32;
  localparam int LEN_W     = 14;
  localparam int NWORDS    = 4;
  localparam int OWN_BIT   = 31;
  localparam int LEN_LSB   = 16;
  localparam int ES_BIT    = 15;
  localparam int FS_BIT    = 9;
  localparam int LS_BIT    = 8;
  localparam int CHAIN_BIT = 14;
  localparam int NFLAGS    = 2;

  typedef enum logic [2:0] {
    ST_IDLE, ST_FETCH, ST_CHECK, ST_SUSP, ST_RECV, ST_WB
  } state_e;

  function automatic logic [WORD_W-1:0] wb_word(input logic [LEN_W-1:0] len, input logic es);
    logic [WORD_W-1:0] w;
    w = '0;
    w[LEN_LSB +: LEN_W] = len;
    w[ES_BIT] = es;
    w[FS_BIT] = 1'b1;
    w[LS_BIT] = 1'b1;
    return w;
  endfunction
endpackage

// File: rtl/rxw_mem.sv
module rxw_mem import rxw_pkg::*; #(
  parameter int AW = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              eng_we_i,
  input  logic [AW-1:0]     eng_waddr_i,
  input  logic [WORD_W-1:0] eng_wdata_i,
  input  logic [AW-1:0]     eng_raddr_i,
  output logic [WORD_W-1:0] eng_rdata_o,
  input  logic              sw_we_i,
  input  logic [AW-1:0]     sw_addr_i,
  input  logic [WORD_W-1:0] sw_wdata_i,
  output logic [WORD_W-1:0] sw_rdata_o
);
  localparam int DEPTH = 1 << AW;

  logic [WORD_W-1:0] mem [DEPTH];

  // software write lands last, so it wins on an address clash
  always_ff @(posedge clk_i) begin
    if (eng_we_i) mem[eng_waddr_i] <= eng_wdata_i;
    if (sw_we_i)  mem[sw_addr_i]   <= sw_wdata_i;
  end

  assign eng_rdata_o = mem[eng_raddr_i];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sw_rdata_o <= '0;
    else         sw_rdata_o <= mem[sw_addr_i];
  end
endmodule

// File: rtl/rxw_status.sv
module rxw_status import rxw_pkg::*; (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [NFLAGS-1:0] set_i,
  input  logic [NFLAGS-1:0] clr_i,
  output logic [NFLAGS-1:0] flag_o
);
  for (genvar g = 0; g < NFLAGS; g++) begin : g_flag
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)       flag_o[g] <= 1'b0;
      else if (set_i[g]) flag_o[g] <= 1'b1;
      else if (clr_i[g]) flag_o[g] <= 1'b0;
    end
  end
endmodule

// File: rtl/rxw_engine.sv
module rxw_engine import rxw_pkg::*; #(
  parameter int AW = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic [AW-1:0]     base_i,
  input  logic              poll_i,
  input  logic              rx_valid_i,
  input  logic [7:0]        rx_data_i,
  input  logic              rx_last_i,
  input  logic              rx_err_i,
  output logic              rx_ready_o,
  output logic [AW-1:0]     rd_addr_o,
  input  logic [WORD_W-1:0] rd_data_i,
  output logic              wr_en_o,
  output logic [AW-1:0]     wr_addr_o,
  output logic [WORD_W-1:0] wr_data_o,
  output logic              done_o,
  output logic              unavail_o
);
  localparam int IDX_W = $clog2(NWORDS);

  state_e            st;
  logic [AW-1:0]     ptr;
  logic [IDX_W-1:0]  widx;
  logic              own_q, chain_q, trunc_q, es_q;
  logic [LEN_W-1:0]  size_q, cnt_q;
  logic [AW-1:0]     buf_q, nxt_q;
  logic [WORD_W-1:0] acc_q, acc_nxt;
  logic              room, take;
  logic              unused_rd;

  assign unused_rd = ^rd_data_i;

  assign room    = cnt_q < size_q;
  assign take    = (st == ST_RECV) && rx_valid_i;
  assign acc_nxt = ((cnt_q[1:0] == 2'd0) ? '0 : acc_q)
                 | (WORD_W'(rx_data_i) << (8 * cnt_q[1:0]));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st      <= ST_IDLE;
      ptr     <= '0;
      widx    <= '0;
      own_q   <= 1'b0;
      chain_q <= 1'b0;
      size_q  <= '0;
      buf_q   <= '0;
      nxt_q   <= '0;
      cnt_q   <= '0;
      acc_q   <= '0;
      trunc_q <= 1'b0;
      es_q    <= 1'b0;
    end else begin
      unique case (st)
        ST_IDLE: if (start_i) begin
          ptr  <= base_i;
          widx <= '0;
          st   <= ST_FETCH;
        end
        ST_FETCH: begin
          unique case (widx)
            2'd0: own_q <= rd_data_i[OWN_BIT];
            2'd1: begin
              size_q  <= rd_data_i[LEN_W-1:0];
              chain_q <= rd_data_i[CHAIN_BIT];
            end
            2'd2: buf_q <= rd_data_i[AW-1:0];
            default: nxt_q <= rd_data_i[AW-1:0];
          endcase
          widx <= widx + 1'b1;
          if (widx == IDX_W'(NWORDS - 1)) st <= ST_CHECK;
        end
        ST_CHECK: begin
          if (own_q) begin
            cnt_q   <= '0;
            acc_q   <= '0;
            trunc_q <= 1'b0;
            st      <= ST_RECV;
          end else begin
            st <= ST_SUSP;
          end
        end
        ST_SUSP: if (poll_i) begin
          widx <= '0;
          st   <= ST_FETCH;
        end
        ST_RECV: if (rx_valid_i) begin
          if (room) begin
            acc_q <= acc_nxt;
            cnt_q <= cnt_q + 1'b1;
          end else begin
            trunc_q <= 1'b1;
          end
          if (rx_last_i) begin
            es_q <= rx_err_i | trunc_q | ~room;
            st   <= ST_WB;
          end
        end
        ST_WB: begin
          ptr  <= chain_q ? nxt_q : ptr + AW'(NWORDS);
          widx <= '0;
          st   <= ST_FETCH;
        end
        default: st <= ST_IDLE;
      endcase
    end
  end

  assign rd_addr_o  = ptr + AW'(widx);
  assign rx_ready_o = (st == ST_RECV);
  assign done_o     = (st == ST_WB);
  assign unavail_o  = (st == ST_CHECK) && !own_q;
  assign wr_en_o    = (take && room) || done_o;
  assign wr_addr_o  = done_o ? ptr : buf_q + AW'(cnt_q >> 2);
  assign wr_data_o  = done_o ? wb_word(cnt_q, es_q) : acc_nxt;
endmodule

// File: rtl/rxdesc_walker.sv
module rxdesc_walker import rxw_pkg::*; #(
  parameter int AW = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic [AW-1:0]     base_i,
  input  logic              poll_i,
  input  logic              rx_valid_i,
  input  logic [7:0]        rx_data_i,
  input  logic              rx_last_i,
  input  logic              rx_err_i,
  output logic              rx_ready_o,
  input  logic              sw_we_i,
  input  logic [AW-1:0]     sw_addr_i,
  input  logic [WORD_W-1:0] sw_wdata_i,
  output logic [WORD_W-1:0] sw_rdata_o,
  input  logic [NFLAGS-1:0] stat_clr_i,
  output logic [NFLAGS-1:0] stat_o
);
  logic              eng_we;
  logic [AW-1:0]     eng_waddr, eng_raddr;
  logic [WORD_W-1:0] eng_wdata, eng_rdata;
  logic              done_set, unavail_set;

  rxw_engine #(.AW(AW)) u_engine (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .start_i    (start_i),
    .base_i     (base_i),
    .poll_i     (poll_i),
    .rx_valid_i (rx_valid_i),
    .rx_data_i  (rx_data_i),
    .rx_last_i  (rx_last_i),
    .rx_err_i   (rx_err_i),
    .rx_ready_o (rx_ready_o),
    .rd_addr_o  (eng_raddr),
    .rd_data_i  (eng_rdata),
    .wr_en_o    (eng_we),
    .wr_addr_o  (eng_waddr),
    .wr_data_o  (eng_wdata),
    .done_o     (done_set),
    .unavail_o  (unavail_set)
  );

  rxw_mem #(.AW(AW)) u_mem (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .eng_we_i    (eng_we),
    .eng_waddr_i (eng_waddr),
    .eng_wdata_i (eng_wdata),
    .eng_raddr_i (eng_raddr),
    .eng_rdata_o (eng_rdata),
    .sw_we_i     (sw_we_i),
    .sw_addr_i   (sw_addr_i),
    .sw_wdata_i  (sw_wdata_i),
    .sw_rdata_o  (sw_rdata_o)
  );

  rxw_status u_status (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .set_i  ({unavail_set, done_set}),
    .clr_i  (stat_clr_i),
    .flag_o (stat_o)
  );
endmodule

// File: rtl/rxw_chk.sv
module rxw_chk import rxw_pkg::*; (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              start_i,
  input logic              rx_ready_o,
  input logic [NFLAGS-1:0] stat_o,
  input logic [NFLAGS-1:0] stat_clr_i,
  input logic              eng_we,
  input logic [WORD_W-1:0] eng_wdata,
  input logic              done_set,
  input logic              unavail_set
);
  logic started;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      started <= 1'b0;
    else if (start_i) started <= 1'b1;
  end

  // R1
  idle_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !started |-> (!rx_ready_o && !eng_we));

  // R8
  unavail_stall_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    unavail_set |=> (!rx_ready_o && stat_o[1]));

  // R4
  wb_word_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_set |-> (eng_we && !eng_wdata[OWN_BIT] && eng_wdata[FS_BIT] && eng_wdata[LS_BIT]));

  // R10
  done_release_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(stat_o[0]) |-> $past(eng_we && !eng_wdata[OWN_BIT]));

  // R10
  w1c_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (stat_o[0] && stat_clr_i[0] && !done_set) |=> !stat_o[0]);

  // R10
  set_wins_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_set |=> stat_o[0]);
endmodule

bind rxdesc_walker rxw_chk u_rxw_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .start_i     (start_i),
  .rx_ready_o  (rx_ready_o),
  .stat_o      (stat_o),
  .stat_clr_i  (stat_clr_i),
  .eng_we      (eng_we),
  .eng_wdata   (eng_wdata),
  .done_set    (done_set),
  .unavail_set (unavail_set)
);

// File: tb/rxdesc_walker_tb_top.sv
module rxdesc_walker_tb_top;
  logic        clk = 0;
  logic        rst_n = 0;
  logic        start = 0;
  logic [7:0]  base = 8'h10;
  logic        poll = 0;
  logic        rx_valid = 0, rx_last = 0, rx_err = 0;
  logic [7:0]  rx_data = 0;
  logic        rx_ready;
  logic        sw_we = 0;
  logic [7:0]  sw_addr = 0;
  logic [31:0] sw_wdata = 0, sw_rdata;
  logic [1:0]  stat_clr = 0, stat;

  int n_chk = 0, n_fail = 0, n_sent = 0, n_done = 0;

  typedef struct {
    logic [7:0]  a;
    logic [31:0] d;
    bit          last;
    string       tag;
  } item_t;
  item_t exp_q[$];

  always #5 clk = ~clk;

  rxdesc_walker #(.AW(8)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .base_i(base), .poll_i(poll),
    .rx_valid_i(rx_valid), .rx_data_i(rx_data), .rx_last_i(rx_last), .rx_err_i(rx_err),
    .rx_ready_o(rx_ready), .sw_we_i(sw_we), .sw_addr_i(sw_addr), .sw_wdata_i(sw_wdata),
    .sw_rdata_o(sw_rdata), .stat_clr_i(stat_clr), .stat_o(stat)
  );

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic sw_wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    sw_we = 1; sw_addr = a; sw_wdata = d;
    @(negedge clk);
    sw_we = 0;
  endtask

  task automatic sw_rd(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk);
    sw_we = 0; sw_addr = a;
    @(negedge clk);
    d = sw_rdata;
  endtask

  task automatic pulse_clr(input logic [1:0] m);
    @(negedge clk); stat_clr = m;
    @(negedge clk); stat_clr = 0;
  endtask

  task automatic pulse_poll();
    @(negedge clk); poll = 1;
    @(negedge clk); poll = 0;
  endtask

  function automatic logic [31:0] wb(input int len, input bit es);
    return (32'(len) << 16) | (32'(es) << 15) | 32'h0000_0300;
  endfunction

  // driver: queues expected memory contents, then streams the frame
  task automatic send_frame(input logic [7:0] desc, input logic [7:0] bufa, input int size,
                            input int n, input bit err, input logic [7:0] b0,
                            input string tag, input bit clr_end);
    int  s  = (n < size) ? n : size;
    bit  es = err || (n > size);
    for (int w = 0; w < (s + 3) / 4; w++) begin
      logic [31:0] v = '0;
      for (int l = 0; l < 4; l++)
        if (w * 4 + l < s) v[8*l +: 8] = b0 + 8'(w * 4 + l);
      exp_q.push_back('{bufa + 8'(w), v, 1'b0, "R3 buffer word"});
    end
    exp_q.push_back('{desc, wb(s, es), 1'b1, tag});
    n_sent++;
    @(negedge clk);
    for (int i = 0; i < n; i++) begin
      rx_valid = 1; rx_data = b0 + 8'(i);
      rx_last = (i == n - 1); rx_err = err && (i == n - 1);
      while (!rx_ready) @(negedge clk);
      @(negedge clk);
    end
    rx_valid = 0; rx_last = 0; rx_err = 0;
    if (clr_end) begin
      stat_clr = 2'b01;
      @(negedge clk);
      stat_clr = 0;
      chk(stat[0] == 1'b1, "R10 set beats same-cycle clear", 32'(stat[0]), 1);
    end
    wait (n_done == n_sent);
  endtask

  // monitor: on each done flag, compare memory against the queue
  initial begin
    forever begin
      @(negedge clk);
      if (rst_n && stat[0]) begin
        item_t it;
        logic [31:0] got;
        if (exp_q.size() == 0) begin
          chk(1'b0, "R10 unexpected done flag", 32'(stat[0]), 0);
        end else begin
          do begin
            it = exp_q.pop_front();
            sw_rd(it.a, got);
            chk(got == it.d, it.tag, got, it.d);
          end while (!it.last && exp_q.size() > 0);
        end
        pulse_clr(2'b01);
        chk(stat[0] == 1'b0, "R10 write-one clear", 32'(stat[0]), 0);
        n_done++;
      end
    end
  end

  initial begin
    repeat (50000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL R2 watchdog: actual %h expected %h", 0, 1);
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    logic [31:0] v;
    repeat (3) @(negedge clk);
    chk(stat == 2'b00, "R1 reset status", 32'(stat), 0);
    chk(rx_ready == 1'b0, "R1 reset ready", 32'(rx_ready), 0);
    rst_n = 1;

    sw_wr(8'hF0, 32'hA5A5_5A5A);
    sw_rd(8'hF0, v);
    chk(v == 32'hA5A5_5A5A, "R11 memory port", v, 32'hA5A5_5A5A);

    // D0 @10 chained->14, D1 @14 chained->20, D2 @20 sequential, D3 @24 sw-owned ->10
    sw_wr(8'h10, 32'h8000_0000); sw_wr(8'h11, 32'h0000_4008); sw_wr(8'h12, 32'h40); sw_wr(8'h13, 32'h14);
    sw_wr(8'h14, 32'h8000_0000); sw_wr(8'h15, 32'h0000_4010); sw_wr(8'h16, 32'h60); sw_wr(8'h17, 32'h20);
    sw_wr(8'h20, 32'h8000_0000); sw_wr(8'h21, 32'h0000_000C); sw_wr(8'h22, 32'h80); sw_wr(8'h23, 32'h7E);
    sw_wr(8'h24, 32'h0000_0000); sw_wr(8'h25, 32'h0000_400C); sw_wr(8'h26, 32'hA0); sw_wr(8'h27, 32'h10);
    sw_wr(8'h83, 32'hDEAD_BEEF);

    repeat (5) @(negedge clk);
    chk(rx_ready == 1'b0, "R1 idle before start", 32'(rx_ready), 0);
    start = 1;

    send_frame(8'h10, 8'h40, 8, 5, 1'b0, 8'h10, "R4 descriptor word", 1'b0);
    send_frame(8'h14, 8'h60, 16, 16, 1'b1, 8'h30, "R5 error summary", 1'b0);
    send_frame(8'h20, 8'h80, 12, 15, 1'b0, 8'h50, "R6 truncated", 1'b0);
    sw_rd(8'h83, v);
    chk(v == 32'hDEAD_BEEF, "R6 word past buffer", v, 32'hDEAD_BEEF);

    // sequential step landed on D3, which software still owns
    repeat (8) @(negedge clk);
    chk(stat[1] == 1'b1, "R8 unavailable flag", 32'(stat[1]), 1);
    chk(rx_ready == 1'b0, "R8 stalled", 32'(rx_ready), 0);
    sw_rd(8'h24, v);
    chk(v == 32'h0, "R8 descriptor untouched", v, 0);
    pulse_clr(2'b10);
    chk(stat[1] == 1'b0, "R10 clear unavailable", 32'(stat[1]), 0);
    pulse_poll();
    repeat (8) @(negedge clk);
    chk(stat[1] == 1'b1, "R9 poll refetches owned-by-software", 32'(stat[1]), 1);

    sw_wr(8'h24, 32'h8000_0000);
    pulse_clr(2'b10);
    pulse_poll();
    repeat (8) @(negedge clk);
    chk(stat[1] == 1'b0 && rx_ready == 1'b1, "R9 poll resumes", {stat[1], rx_ready}, 32'b01);
    send_frame(8'h24, 8'hA0, 12, 4, 1'b0, 8'h70, "R7 sequential next", 1'b0);

    // D3 chains back to D0, already returned to software
    repeat (8) @(negedge clk);
    chk(stat[1] == 1'b1, "R7 chained back to first", 32'(stat[1]), 1);
    sw_wr(8'h10, 32'h8000_0000);
    pulse_clr(2'b10);
    pulse_poll();
    send_frame(8'h10, 8'h40, 8, 8, 1'b0, 8'h90, "R6 exact fit", 1'b1);

    repeat (4) @(negedge clk);
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule